// File: doc/BRIEF.md
# Constant On-Time Gate Timing Controller

This block times the two gate enables of one synchronous buck channel with a constant on-time scheme. A switching cycle starts only when the output has sagged below its reference. The upper gate then stays on for a fixed number of clock cycles. After that the lower gate conducts until the next cycle, or until the inductor current reaches zero. Cycle starts are held back by two things: a minimum off-time measured from the falling edge of the upper gate, and a valley over-current flag that applies while the lower switch carries current.

Two light-load behaviours are chosen by one select pin. In plain diode emulation, the channel simply goes quiet between demand pulses. In ultrasonic mode, a watch timer forces a shortened upper pulse whenever no cycle has started for a set period. If the output is still above its band at that moment, the lower switch is first turned on to pull the output down, and the short pulse follows once the output comes back. Dead time is inserted in both directions. All analog quantities (comparators, current sense, on-time from input voltage) arrive as digital flags and a count.

Top module: `cot_pwm_timer`

## Requirements
- R1: While reset is held and after it is released with no demand, both `hs_gate` and `ls_gate` are low.
- R2: With both gates off and the minimum off-time elapsed, `below_ref` high makes `hs_gate` rise at the next clock edge. `hs_gate` then stays high for `on_cycles` cycles, and a value of 0 is treated as 1.
- R3: When `hs_gate` falls, both gates stay low for `DT_LS_CYC` cycles. `ls_gate` then rises and stays high while `i_zero` is low.
- R4: Once `hs_gate` has fallen, it stays low for at least `MIN_OFF_CYC` cycles. In continuous conduction the low time is exactly `MIN_OFF_CYC + DT_HS_CYC + 1` cycles.
- R5: A cycle started while `ls_gate` is high drops `ls_gate` and leaves both gates low for `DT_HS_CYC` cycles before `hs_gate` rises.
- R6: While `ls_gate` is high from normal conduction, `valley_over` high blocks any new cycle. `hs_gate` rises `DT_HS_CYC + 1` cycles after the flag clears. While both gates are off, the flag has no effect.
- R7: `i_zero` high while the lower switch conducts after a pulse turns `ls_gate` off at the next edge. Both gates then stay low until a new demand.
- R8: `skip_dem` = 1 selects diode emulation, in which no pulse is ever forced. `skip_dem` = 0 selects ultrasonic mode.
- R9: In ultrasonic mode with no demand, `hs_gate` rises every `USM_PERIOD` cycles, counted from rising edge to rising edge. Each such pulse lasts `TON_SHORT` cycles.
- R10: In ultrasonic mode, if `above_band` is high when a forced pulse is due, `ls_gate` rises at once and stays high, ignoring `i_zero`, while `above_band` stays high. `hs_gate` then rises `DT_HS_CYC + 1` cycles after `above_band` falls, for `TON_SHORT` cycles.
- R11: `hs_gate` and `ls_gate` are never high in the same cycle, under any sequence of inputs, including a change of `skip_dem` in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_ref | input | 1 | Output voltage is below reference (cycle demand) |
| valley_over | input | 1 | Lower-switch current above the valley limit |
| i_zero | input | 1 | Inductor current has reached the zero-crossing level |
| skip_dem | input | 1 | Light-load mode: 1 diode emulation, 0 ultrasonic |
| above_band | input | 1 | Output voltage above its upper band |
| on_cycles | input | TON_W | Upper-gate on-time in clock cycles |
| hs_gate | output | 1 | Upper (high-side) gate enable |
| ls_gate | output | 1 | Lower (low-side) gate enable |

## Verification
Gate outputs decode the registered state, so every input change acts at the next clock edge. A demand seen while idle raises the upper gate one cycle later. Releasing the valley flag or the over-band flag raises the upper gate `DT_HS_CYC + 1` cycles later. A zero crossing drops the lower gate one cycle later. The bench drives and samples on the falling clock edge and counts falling edges between events, so every pulse width, dead time, off-time and forced-pulse period is compared as an exact cycle count.

// File: rtl/cot_pkg.sv
package cot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // both switches off
        ST_HS   = 3'd1,  // upper switch on
        ST_DTL  = 3'd2,  // dead time ahead of lower switch
        ST_LS   = 3'd3,  // lower switch conducting
        ST_DTH  = 3'd4,  // dead time ahead of upper switch
        ST_PULL = 3'd5   // forced lower-switch pull-down
    } cot_state_e;

    typedef struct packed {
        cot_state_e st;
        logic       short_pend;  // next upper pulse uses the short on-time
    } cot_ctl_s;

endpackage

// File: rtl/cot_countdown.sv
module cot_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/cot_idle_watch.sv
module cot_idle_watch #(
    parameter int PERIOD = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);

    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LIM = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear) begin
            cnt_d = '0;
        end else if (cnt_q == LIM) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == LIM);

endmodule

// File: rtl/cot_pwm_timer.sv
module cot_pwm_timer
    import cot_pkg::*;
#(
    parameter int TON_W       = 8,
    parameter int MIN_OFF_CYC = 20,
    parameter int DT_LS_CYC   = 2,
    parameter int DT_HS_CYC   = 3,
    parameter int TON_SHORT   = 4,
    parameter int USM_PERIOD  = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             below_ref,
    input  logic             valley_over,
    input  logic             i_zero,
    input  logic             skip_dem,
    input  logic             above_band,
    input  logic [TON_W-1:0] on_cycles,
    output logic             hs_gate,
    output logic             ls_gate
);

    localparam int FIX_MAX  = (DT_LS_CYC > DT_HS_CYC) ?
                              ((DT_LS_CYC > TON_SHORT) ? DT_LS_CYC : TON_SHORT) :
                              ((DT_HS_CYC > TON_SHORT) ? DT_HS_CYC : TON_SHORT);
    localparam int FIX_W    = $clog2(FIX_MAX + 1);
    localparam int PH_W     = (TON_W > FIX_W) ? TON_W : FIX_W;
    localparam int MO_W     = $clog2(MIN_OFF_CYC + 1);
    localparam logic [PH_W-1:0] SHORT_M1 = PH_W'(TON_SHORT - 1);
    localparam logic [PH_W-1:0] DTL_M1   = PH_W'(DT_LS_CYC - 1);
    localparam logic [PH_W-1:0] DTH_M1   = PH_W'(DT_HS_CYC - 1);
    localparam logic [MO_W-1:0] MO_VAL   = MO_W'(MIN_OFF_CYC);

    cot_ctl_s ctl_d, ctl_q;

    logic            ph_done, mo_done, usm_exp;
    logic            ph_load, mo_load, usm_clear;
    logic [PH_W-1:0] ph_val, on_ext, on_m1;
    logic            start_ok;

    // phase timer: on-time and both dead times
    cot_countdown #(.W(PH_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .done     (ph_done)
    );

    // minimum off-time, started when the upper gate falls
    cot_countdown #(.W(MO_W)) u_minoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mo_load),
        .load_val (MO_VAL),
        .done     (mo_done)
    );

    // time since the last upper-gate rise, for ultrasonic mode
    cot_idle_watch #(.PERIOD(USM_PERIOD)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (usm_clear),
        .expired (usm_exp)
    );

    assign on_ext   = PH_W'(on_cycles);
    assign on_m1    = (on_ext == '0) ? '0 : on_ext - 1'b1;
    assign start_ok = below_ref && mo_done;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_ok) begin
                    ctl_d.st         = ST_HS;
                    ctl_d.short_pend = 1'b0;
                end else if (!skip_dem && usm_exp) begin
                    ctl_d.short_pend = 1'b1;
                    ctl_d.st         = above_band ? ST_PULL : ST_HS;
                end
            end
            ST_HS: begin
                if (ph_done) begin
                    ctl_d.st         = ST_DTL;
                    ctl_d.short_pend = 1'b0;
                end
            end
            ST_DTL: begin
                if (ph_done) ctl_d.st = ST_LS;
            end
            ST_LS: begin
                if (i_zero) begin
                    ctl_d.st = ST_IDLE;
                end else if (start_ok && !valley_over) begin
                    ctl_d.st         = ST_DTH;
                    ctl_d.short_pend = 1'b0;
                end
            end
            ST_DTH: begin
                if (ph_done) ctl_d.st = ST_HS;
            end
            ST_PULL: begin
                if (!above_band) ctl_d.st = ST_DTH;
            end
            default: begin
                ctl_d.st         = ST_IDLE;
                ctl_d.short_pend = 1'b0;
            end
        endcase
    end

    always_comb begin
        ph_load = (ctl_d.st != ctl_q.st);
        case (ctl_d.st)
            ST_HS:   ph_val = ctl_d.short_pend ? SHORT_M1 : on_m1;
            ST_DTL:  ph_val = DTL_M1;
            ST_DTH:  ph_val = DTH_M1;
            default: ph_val = '0;
        endcase
        mo_load   = (ctl_q.st == ST_HS) && (ctl_d.st != ST_HS);
        usm_clear = (ctl_d.st == ST_HS) && (ctl_q.st != ST_HS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, short_pend: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hs_gate = (ctl_q.st == ST_HS);
    assign ls_gate = (ctl_q.st == ST_LS) || (ctl_q.st == ST_PULL);

    assert_gates_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    assert_dead_before_ls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_gate) |-> !ls_gate);

    assert_dead_before_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> !$past(ls_gate));

    assert_min_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> $past(mo_done));

    assert_valley_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LS && valley_over && !i_zero) |=> ls_gate);

    assert_zero_cross_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LS && i_zero) |=> (!ls_gate && !hs_gate));

    assert_pull_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PULL && above_band) |=> (ls_gate && !hs_gate));

endmodule

// File: tb/tb_cot_pwm_timer.sv
module tb_cot_pwm_timer;

    localparam int TON_W       = 8;
    localparam int MIN_OFF_CYC = 20;
    localparam int DT_LS_CYC   = 2;
    localparam int DT_HS_CYC   = 3;
    localparam int TON_SHORT   = 4;
    localparam int USM_PERIOD  = 400;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             below_ref = 1'b0;
    logic             valley_over = 1'b0;
    logic             i_zero = 1'b0;
    logic             skip_dem = 1'b1;
    logic             above_band = 1'b0;
    logic [TON_W-1:0] on_cycles = 8'd10;
    logic             hs_gate, ls_gate;

    int checks = 0;
    int errors = 0;
    int overlap = 0;

    always #5 clk = ~clk;

    cot_pwm_timer #(
        .TON_W(TON_W), .MIN_OFF_CYC(MIN_OFF_CYC), .DT_LS_CYC(DT_LS_CYC),
        .DT_HS_CYC(DT_HS_CYC), .TON_SHORT(TON_SHORT), .USM_PERIOD(USM_PERIOD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .below_ref(below_ref), .valley_over(valley_over),
        .i_zero(i_zero), .skip_dem(skip_dem), .above_band(above_band),
        .on_cycles(on_cycles), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    always @(negedge clk) if (rst_n && hs_gate && ls_gate) overlap++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic hs_width(output int w);
        w = 0;
        while (hs_gate && w < 1000) begin
            w++;
            tick();
        end
    endtask

    task automatic settle_idle;
        below_ref = 1'b0;
        i_zero = 1'b1;
        repeat (30) tick();
        i_zero = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) tick();
        chk("R1 gates in reset", int'(hs_gate) + int'(ls_gate), 0);
        rst_n = 1'b1;
        repeat (5) tick();
        chk("R1 gates after reset", int'(hs_gate) + int'(ls_gate), 0);
    endtask

    task automatic t_dem_pulse;
        int w, n, seen;
        skip_dem = 1'b1;
        repeat (30) tick();
        on_cycles = 8'd10;
        below_ref = 1'b1;
        tick();
        chk("R2 rise one cycle after demand", int'(hs_gate), 1);
        below_ref = 1'b0;
        hs_width(w);
        chk("R2 on-time width", w, 10);
        n = 0;
        while (!ls_gate && n < 50) begin
            n++;
            tick();
        end
        chk("R3 dead time before lower gate", n, DT_LS_CYC);
        repeat (5) tick();
        chk("R3 lower gate holds without zero crossing", int'(ls_gate), 1);
        i_zero = 1'b1;
        tick();
        chk("R7 zero crossing drops lower gate", int'(ls_gate) + int'(hs_gate), 0);
        i_zero = 1'b0;
        seen = 0;
        repeat (20) begin
            tick();
            if (hs_gate || ls_gate) seen++;
        end
        chk("R7 both off until demand", seen, 0);
    endtask

    task automatic t_ccm;
        int w, gap, run;
        on_cycles = 8'd8;
        repeat (30) tick();
        below_ref = 1'b1;
        tick();
        chk("R2 rise on held demand", int'(hs_gate), 1);
        hs_width(w);
        chk("R2 on-time width 8", w, 8);
        gap = 0;
        run = 0;
        while (!hs_gate && gap < 200) begin
            gap++;
            if (!ls_gate) run++;
            else run = 0;
            tick();
        end
        chk("R4 off-time at least minimum", int'(gap >= MIN_OFF_CYC), 1);
        chk("R4 exact continuous off-time", gap, MIN_OFF_CYC + DT_HS_CYC + 1);
        chk("R5 dead time before upper gate", run, DT_HS_CYC);
        below_ref = 1'b0;
        hs_width(w);
        settle_idle();
    endtask

    task automatic t_valley;
        int w, n, seen;
        on_cycles = 8'd6;
        repeat (30) tick();
        below_ref = 1'b1;
        tick();
        below_ref = 1'b0;
        hs_width(w);
        repeat (4) tick();
        chk("R6 lower gate conducting", int'(ls_gate), 1);
        valley_over = 1'b1;
        below_ref = 1'b1;
        seen = 0;
        repeat (40) begin
            tick();
            if (hs_gate) seen++;
        end
        chk("R6 valley flag blocks start", seen, 0);
        chk("R6 lower gate held", int'(ls_gate), 1);
        valley_over = 1'b0;
        n = 0;
        while (!hs_gate && n < 50) begin
            tick();
            n++;
        end
        chk("R6 start after valley clears", n, DT_HS_CYC + 1);
        below_ref = 1'b0;
        hs_width(w);
        settle_idle();
        valley_over = 1'b1;
        below_ref = 1'b1;
        tick();
        chk("R6 valley flag ignored when idle", int'(hs_gate), 1);
        below_ref = 1'b0;
        valley_over = 1'b0;
        hs_width(w);
        settle_idle();
    endtask

    task automatic t_ton_zero;
        int w;
        on_cycles = 8'd0;
        below_ref = 1'b1;
        tick();
        below_ref = 1'b0;
        chk("R2 rise with zero on-time", int'(hs_gate), 1);
        hs_width(w);
        chk("R2 zero on-time treated as one", w, 1);
        settle_idle();
    endtask

    task automatic t_dem_no_force;
        int seen;
        skip_dem = 1'b1;
        i_zero = 1'b1;
        seen = 0;
        repeat (USM_PERIOD + 200) begin
            tick();
            if (hs_gate || ls_gate) seen++;
        end
        chk("R8 diode emulation forces nothing", seen, 0);
    endtask

    task automatic t_usm;
        int n, w, p;
        skip_dem = 1'b0;
        i_zero = 1'b1;
        n = 0;
        while (!hs_gate && n < 2 * USM_PERIOD) begin
            tick();
            n++;
        end
        chk("R8 ultrasonic mode forces a pulse", int'(hs_gate), 1);
        hs_width(w);
        chk("R9 short pulse width", w, TON_SHORT);
        p = w;
        while (!hs_gate && p < 4 * USM_PERIOD) begin
            p++;
            tick();
        end
        chk("R9 forced pulse period", p, USM_PERIOD);
        hs_width(w);
        repeat (10) tick();
    endtask

    task automatic t_pull;
        int n, seen, w;
        above_band = 1'b1;
        n = 0;
        seen = 0;
        while (!ls_gate && n < 2 * USM_PERIOD) begin
            if (hs_gate) seen++;
            tick();
            n++;
        end
        chk("R10 lower gate pulls down first", int'(ls_gate), 1);
        chk("R10 no upper pulse while above band", seen, 0);
        repeat (20) tick();
        chk("R10 pull-down held, zero crossing ignored",
            int'(ls_gate) * 2 + int'(hs_gate), 2);
        above_band = 1'b0;
        n = 0;
        while (!hs_gate && n < 50) begin
            tick();
            n++;
        end
        chk("R10 short pulse after pull-down", n, DT_HS_CYC + 1);
        hs_width(w);
        chk("R10 short pulse width", w, TON_SHORT);
        repeat (10) tick();
    endtask

    task automatic t_mode_churn;
        for (int i = 0; i < 3000; i++) begin
            tick();
            skip_dem    = ((i / 37) % 2) == 0;
            below_ref   = (i % 11) < 4;
            i_zero      = (i % 13) == 0;
            valley_over = (i % 17) < 3;
            above_band  = (i % 29) < 2;
            on_cycles   = TON_W'(3 + i % 5);
        end
        chk("R11 gates never overlap", overlap, 0);
    endtask

    initial begin
        t_reset();
        t_dem_pulse();
        t_ccm();
        t_valley();
        t_ton_zero();
        t_dem_no_force();
        t_usm();
        t_pull();
        t_mode_churn();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule